// File: doc/BRIEF.md
# SPI Slave Host Port with Busy and Interrupt Sideband

This block connects an external host controller to an on-chip processor over a four-wire serial link. The host is the clock master. It reads and writes whole bytes, and the block queues them in two small byte FIFOs. The receive FIFO holds bytes written by the host. The transmit FIFO holds bytes that the processor has queued for the host. The processor side of each FIFO is a simple push or pop port.

Two sideband outputs control the exchange. The busy output tells the host to hold back its next byte while the receive side cannot take it. The interrupt output tells the host that the processor has a message waiting. The operating mode is captured from two mode pins when reset ends. Only the SPI slave setting enables the port. The serial clock, data in and chip select are resynchronised into the core clock, and serial clock edges are found there. The serial clock must therefore run below half the core clock rate.

Top module: `spi_hostport`

## Requirements
- R1: The mode value is captured from `mode_pins` on the last clock edge at which `rst` is high, and later pin changes have no effect until the next reset. Value 2'b01 selects SPI slave and enables the port. For any other value the port ignores host transfers: no byte is received, `spi_miso` stays 0 and the transmit FIFO is not popped.
- R2: In each byte the host sends, the bit on `spi_mosi` is sampled at every rising `spi_sclk` edge, most significant bit first. After the eighth bit, the byte is appended to the receive FIFO. Bytes are read out at `rx_rd_data` in the order they arrived.
- R3: After `spi_cs_n` falls, `spi_miso` carries the most significant bit of the transmit FIFO head before the first rising edge. It advances by one bit after each falling edge. Further bytes within the same chip-select window follow without a gap.
- R4: A byte slot that starts while the transmit FIFO is empty is shifted out as 0x00.
- R5: `host_busy` is high while the receive FIFO is full. It is also high for the cycle in which a completed byte is being written into that FIFO. It goes low once a slot is free.
- R6: `host_irq` is high whenever the transmit FIFO holds a byte. A queued byte is removed only after its eighth rising edge, so `host_irq` falls only after the host has clocked out the last queued byte.
- R7: When `spi_cs_n` rises before eight bits have been clocked, the partial byte is discarded and nothing enters the receive FIFO. A transmit byte that was only partly sent stays queued and is sent again in full in the next transfer.
- R8: While `spi_cs_n` is high, `spi_sclk` edges are ignored and `spi_miso` is 0.
- R9: After reset both FIFOs are empty, and `host_busy`, `host_irq` and `spi_miso` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_pins | input | 2 | Mode straps captured at reset release (bit1: 0 SPI / 1 I2C; bit0: 1 slave / 0 master) |
| spi_sclk | input | 1 | Serial clock from host, idle low |
| spi_mosi | input | 1 | Serial data from host |
| spi_cs_n | input | 1 | Active-low chip select from host |
| spi_miso | output | 1 | Serial data to host |
| host_busy | output | 1 | Flow-control hold-off to host |
| host_irq | output | 1 | Message-waiting request to host |
| tx_wr_en | input | 1 | Processor push into transmit FIFO |
| tx_wr_data | input | 8 | Byte pushed into transmit FIFO |
| tx_full | output | 1 | Transmit FIFO full |
| rx_rd_en | input | 1 | Processor pop from receive FIFO |
| rx_rd_data | output | 8 | Receive FIFO head byte |
| rx_empty | output | 1 | Receive FIFO empty |

## Verification
The assertions rely on assumptions about the block's inputs. The host is assumed to honour the busy output and never complete a byte into a full receive FIFO. The processor is assumed never to push into a full transmit FIFO or pop an empty receive FIFO. Each serial clock phase is assumed to last at least two core cycles, so the resynchronised data is stable at every detected edge. The stimulus runs the serial clock at one eighth of the core rate. It pauses the receive drain only to fill the FIFO to exactly its depth, queues at most two transmit bytes, and pops only when the receive FIFO reports data.

// File: rtl/hostport_pkg.sv
package hostport_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

    // reset value of the synchronised pin vector {cs_n, mosi, sclk}
    localparam logic [2:0] PIN_SYNC_RST = 3'b100;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [1:0] {
        MODE_SPI_MASTER = 2'b00,
        MODE_SPI_SLAVE  = 2'b01,
        MODE_I2C_MASTER = 2'b10,
        MODE_I2C_SLAVE  = 2'b11
    } port_mode_e;

    typedef struct packed {
        logic  valid;
        byte_t data;
    } rx_beat_t;

    function automatic logic mode_enables_port(input port_mode_e m);
        return m == MODE_SPI_SLAVE;
    endfunction

endpackage

// File: rtl/hostport_sync.sv
module hostport_sync #(
    parameter int WIDTH = 3,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d_in};
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/hostport_fifo.sv
module hostport_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic             full,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             empty
);

    localparam int AW = $clog2(DEPTH);
    localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);
    localparam logic [AW:0]   CNT_FULL = (AW+1)'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp, rp;
    logic [AW:0]      cnt;
    logic             do_wr, do_rd;

    assign full  = (cnt == CNT_FULL);
    assign empty = (cnt == '0);
    assign do_wr = wr_en & ~full;
    assign do_rd = rd_en & ~empty;
    assign rd_data = mem[rp];

    always_ff @(posedge clk) begin
        if (do_wr) mem[wp] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_wr) wp <= (wp == PTR_LAST) ? '0 : wp + 1'b1;
            if (do_rd) rp <= (rp == PTR_LAST) ? '0 : rp + 1'b1;
            case ({do_wr, do_rd})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // R5: writers respect the full flag (host honours busy)
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !full);

    // R6: a pop only ever removes a byte that is present
    a_r6_no_underflow: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> !empty);

endmodule

// File: rtl/hostport_serdes.sv
module hostport_serdes
    import hostport_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     enable,
    input  logic     sclk_s,
    input  logic     mosi_s,
    input  logic     csn_s,
    input  logic     tx_valid,
    input  byte_t    tx_head,
    output logic     tx_pop,
    output rx_beat_t rx_out,
    output logic     miso
);

    logic             csn_eff, sclk_d, csn_d;
    logic             rise, fall, cs_fall, cs_rise, boundary;
    logic [CNT_W-1:0] bit_cnt;
    logic             started, tx_live;
    byte_t            shift_in, shift_out;
    rx_beat_t         rx_q;

    always_comb begin
        csn_eff  = csn_s | ~enable;
        rise     = sclk_s & ~sclk_d;
        fall     = ~sclk_s & sclk_d;
        cs_fall  = ~csn_eff & csn_d;
        cs_rise  = csn_eff & ~csn_d;
        boundary = ~csn_eff & fall & started & (bit_cnt == '0);
        tx_pop   = ~csn_eff & ~cs_fall & rise & (bit_cnt == CNT_LAST) & tx_live;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d    <= 1'b0;
            csn_d     <= 1'b1;
            bit_cnt   <= '0;
            started   <= 1'b0;
            tx_live   <= 1'b0;
            shift_in  <= '0;
            shift_out <= '0;
            rx_q      <= '0;
        end else begin
            sclk_d     <= sclk_s;
            csn_d      <= csn_eff;
            rx_q.valid <= 1'b0;
            if (csn_eff) begin
                bit_cnt   <= '0;
                started   <= 1'b0;
                tx_live   <= 1'b0;
                shift_out <= '0;
            end else if (cs_fall || boundary) begin
                shift_out <= tx_valid ? tx_head : '0;
                tx_live   <= tx_valid;
                if (cs_fall) begin
                    bit_cnt <= '0;
                    started <= 1'b0;
                end
            end else if (rise) begin
                shift_in <= {shift_in[BYTE_W-2:0], mosi_s};
                bit_cnt  <= (bit_cnt == CNT_LAST) ? '0 : bit_cnt + 1'b1;
                started  <= 1'b1;
                if (bit_cnt == CNT_LAST) begin
                    rx_q.valid <= 1'b1;
                    rx_q.data  <= {shift_in[BYTE_W-2:0], mosi_s};
                    tx_live    <= 1'b0;
                end
            end else if (fall && started) begin
                shift_out <= {shift_out[BYTE_W-2:0], 1'b0};
            end
        end
    end

    assign miso   = shift_out[BYTE_W-1];
    assign rx_out = rx_q;

    // R2: a completed byte is offered for exactly one cycle
    a_r2_push_single: assert property (@(posedge clk) disable iff (rst)
        rx_q.valid |=> !rx_q.valid);

    // R7: chip select release abandons the bit count and the live byte
    a_r7_abort_clears: assert property (@(posedge clk) disable iff (rst)
        cs_rise |=> (bit_cnt == '0) && !tx_live);

    // R8: MISO quiet once deselect has settled
    a_r8_idle_miso: assert property (@(posedge clk) disable iff (rst)
        (csn_d && csn_eff) |-> !miso);

endmodule

// File: rtl/spi_hostport.sv
module spi_hostport
    import hostport_pkg::*;
#(
    parameter int TX_DEPTH    = 4,
    parameter int RX_DEPTH    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  mode_pins,
    input  logic        spi_sclk,
    input  logic        spi_mosi,
    input  logic        spi_cs_n,
    output logic        spi_miso,
    output logic        host_busy,
    output logic        host_irq,
    input  logic        tx_wr_en,
    input  logic [7:0]  tx_wr_data,
    output logic        tx_full,
    input  logic        rx_rd_en,
    output logic [7:0]  rx_rd_data,
    output logic        rx_empty
);

    port_mode_e mode_q;
    logic       port_en;
    logic [2:0] pins_s;
    logic       tx_empty, tx_pop, rx_full;
    byte_t      tx_head;
    rx_beat_t   rx_beat;

    // mode tracks the straps while reset is held, frozen afterwards
    always_ff @(posedge clk) begin
        if (rst) mode_q <= port_mode_e'(mode_pins);
    end

    assign port_en = mode_enables_port(mode_q);

    hostport_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_SYNC_RST)
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .d_in ({spi_cs_n, spi_mosi, spi_sclk}),
        .q    (pins_s)
    );

    hostport_serdes u_serdes (
        .clk      (clk),
        .rst      (rst),
        .enable   (port_en),
        .sclk_s   (pins_s[0]),
        .mosi_s   (pins_s[1]),
        .csn_s    (pins_s[2]),
        .tx_valid (~tx_empty),
        .tx_head  (tx_head),
        .tx_pop   (tx_pop),
        .rx_out   (rx_beat),
        .miso     (spi_miso)
    );

    hostport_fifo #(.WIDTH(BYTE_W), .DEPTH(TX_DEPTH)) u_tx_fifo (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (tx_wr_en),
        .wr_data (tx_wr_data),
        .full    (tx_full),
        .rd_en   (tx_pop),
        .rd_data (tx_head),
        .empty   (tx_empty)
    );

    hostport_fifo #(.WIDTH(BYTE_W), .DEPTH(RX_DEPTH)) u_rx_fifo (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (rx_beat.valid),
        .wr_data (rx_beat.data),
        .full    (rx_full),
        .rd_en   (rx_rd_en),
        .rd_data (rx_rd_data),
        .empty   (rx_empty)
    );

    assign host_busy = rx_full | rx_beat.valid;
    assign host_irq  = ~tx_empty;

    // R1: captured mode never moves outside reset
    a_r1_mode_frozen: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(mode_q));

    // R6: the request drops only as a result of a completed byte
    a_r6_irq_drop_on_pop: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $fell(host_irq)) |-> $past(tx_pop));

endmodule

// File: tb/spi_hostport_test.sv
module spi_hostport_test;
    import hostport_pkg::*;

    localparam int HALF = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode_pins = 2'b01;
    logic       spi_sclk = 1'b0, spi_mosi = 1'b0, spi_cs_n = 1'b1;
    logic       spi_miso, host_busy, host_irq, tx_full, rx_empty;
    logic       tx_wr_en = 1'b0;
    logic [7:0] tx_wr_data = '0;
    logic       rx_rd_en = 1'b0;
    logic [7:0] rx_rd_data;

    int    checks = 0;
    int    errors = 0;
    byte_t rx_q[$];
    byte_t tx_q[$];
    bit    mon_en = 1'b1;
    byte_t mon_exp;

    always #5 clk = ~clk;

    spi_hostport uut (
        .clk(clk), .rst(rst), .mode_pins(mode_pins),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n),
        .spi_miso(spi_miso), .host_busy(host_busy), .host_irq(host_irq),
        .tx_wr_en(tx_wr_en), .tx_wr_data(tx_wr_data), .tx_full(tx_full),
        .rx_rd_en(rx_rd_en), .rx_rd_data(rx_rd_data), .rx_empty(rx_empty)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // scoreboard monitor: pops received bytes and compares with driver queue
    always @(negedge clk) begin
        if (rx_rd_en) rx_rd_en = 1'b0;
        else if (mon_en && !rst && !rx_empty) begin
            if (rx_q.size() == 0) chk(1'b0, "R2 unexpected byte", int'(rx_rd_data), 0);
            else begin
                mon_exp = rx_q.pop_front();
                chk(rx_rd_data == mon_exp, "R2 received byte", int'(rx_rd_data), int'(mon_exp));
            end
            rx_rd_en = 1'b1;
        end
    end

    initial begin
        repeat (60000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic do_reset(input logic [1:0] m);
        rst = 1'b1;
        mode_pins = m;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        rx_q.delete();
        tx_q.delete();
    endtask

    task automatic tx_push(input byte_t b);
        tx_wr_en = 1'b1;
        tx_wr_data = b;
        @(negedge clk);
        tx_wr_en = 1'b0;
        tx_q.push_back(b);
    endtask

    task automatic spi_bits(input byte_t mo, input int nbits, input bit expect_rx,
                            output byte_t mi, output bit bsy);
        mi = '0;
        bsy = 1'b0;
        if (nbits == BYTE_W && expect_rx) rx_q.push_back(mo);
        for (int i = 0; i < nbits; i++) begin
            spi_mosi = mo[BYTE_W-1-i];
            repeat (HALF) @(negedge clk);
            mi = {mi[BYTE_W-2:0], spi_miso};
            spi_sclk = 1'b1;
            for (int k = 0; k < HALF; k++) begin
                @(negedge clk);
                bsy = bsy | host_busy;
            end
            spi_sclk = 1'b0;
        end
    endtask

    task automatic cs_end();
        repeat (HALF) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (2*HALF) @(negedge clk);
    endtask

    task automatic xfer1(input byte_t mo, input string req, output bit bsy);
        byte_t exp, mi;
        exp = (tx_q.size() > 0) ? tx_q.pop_front() : '0;
        spi_cs_n = 1'b0;
        spi_bits(mo, BYTE_W, 1'b1, mi, bsy);
        cs_end();
        chk(mi == exp, req, int'(mi), int'(exp));
    endtask

    task automatic drain();
        for (int i = 0; i < 60; i++) begin
            if (rx_q.size() == 0 && rx_empty) break;
            @(negedge clk);
        end
        chk(rx_q.size() == 0, "R2 scoreboard drained", rx_q.size(), 0);
    endtask

    initial begin
        bit    bsy, idle_ok;
        byte_t mi, exp;
        @(negedge clk);
        do_reset(2'b01);

        // R9 reset state
        chk(spi_miso == 1'b0, "R9 miso after reset", spi_miso, 0);
        chk(host_busy == 1'b0, "R9 busy after reset", host_busy, 0);
        chk(host_irq == 1'b0, "R9 irq after reset", host_irq, 0);
        chk(rx_empty == 1'b1, "R9 rx empty after reset", rx_empty, 1);
        chk(tx_full == 1'b0, "R9 tx not full after reset", tx_full, 0);

        // R1 straps changed after reset are ignored; R4 empty tx gives 0x00
        mode_pins = 2'b10;
        xfer1(8'h5A, "R4 empty transmit shifts zero", bsy);
        chk(bsy == 1'b1, "R5 busy during byte write", bsy, 1);
        drain();

        // R3/R6 two queued bytes, three bytes in one chip-select window
        tx_push(8'hC3);
        tx_push(8'h17);
        chk(host_irq == 1'b1, "R6 irq with queued bytes", host_irq, 1);
        spi_cs_n = 1'b0;
        exp = tx_q.pop_front();
        spi_bits(8'hA5, BYTE_W, 1'b1, mi, bsy);
        chk(mi == exp, "R3 first byte on miso", int'(mi), int'(exp));
        chk(host_irq == 1'b1, "R6 irq held for second byte", host_irq, 1);
        exp = tx_q.pop_front();
        spi_bits(8'h0F, BYTE_W, 1'b1, mi, bsy);
        chk(mi == exp, "R3 back-to-back byte on miso", int'(mi), int'(exp));
        chk(host_irq == 1'b0, "R6 irq cleared after last byte", host_irq, 0);
        spi_bits(8'h80, BYTE_W, 1'b1, mi, bsy);
        chk(mi == 8'h00, "R4 zero after queue ran dry", int'(mi), 0);
        cs_end();
        drain();

        // R8 clock edges while deselected are ignored
        tx_push(8'h81);
        idle_ok = 1'b1;
        for (int i = 0; i < BYTE_W; i++) begin
            spi_mosi = 1'b1;
            repeat (HALF) @(negedge clk);
            idle_ok = idle_ok & !spi_miso;
            spi_sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            idle_ok = idle_ok & !spi_miso;
            spi_sclk = 1'b0;
        end
        repeat (2*HALF) @(negedge clk);
        chk(idle_ok, "R8 miso low while deselected", !idle_ok, 0);
        chk(rx_empty == 1'b1, "R8 no byte from deselected clocks", rx_empty, 1);
        chk(host_irq == 1'b1, "R8 transmit byte not consumed", host_irq, 1);

        // R7 partial byte discarded, partly sent byte resent
        spi_cs_n = 1'b0;
        spi_bits(8'hFF, 5, 1'b0, mi, bsy);
        cs_end();
        chk(rx_empty == 1'b1, "R7 partial byte dropped", rx_empty, 1);
        chk(host_irq == 1'b1, "R7 partly sent byte kept", host_irq, 1);
        xfer1(8'h3C, "R7 resent byte on miso", bsy);
        drain();
        chk(host_irq == 1'b0, "R6 irq cleared after resend", host_irq, 0);

        // R5 busy when receive FIFO fills
        mon_en = 1'b0;
        xfer1(8'h11, "R4 zero while filling", bsy);
        xfer1(8'h22, "R4 zero while filling", bsy);
        xfer1(8'h44, "R4 zero while filling", bsy);
        chk(host_busy == 1'b0, "R5 not busy with free slot", host_busy, 0);
        xfer1(8'h88, "R4 zero while filling", bsy);
        chk(host_busy == 1'b1, "R5 busy when full", host_busy, 1);
        repeat (20) @(negedge clk);
        chk(host_busy == 1'b1, "R5 busy held while full", host_busy, 1);
        mon_en = 1'b1;
        drain();
        repeat (2) @(negedge clk);
        chk(host_busy == 1'b0, "R5 busy released", host_busy, 0);

        // R1 non-slave strap disables the port
        do_reset(2'b11);
        tx_push(8'h99);
        tx_q.delete();
        spi_cs_n = 1'b0;
        spi_bits(8'hA5, BYTE_W, 1'b0, mi, bsy);
        cs_end();
        chk(mi == 8'h00, "R1 miso silent when disabled", int'(mi), 0);
        chk(rx_empty == 1'b1, "R1 nothing received when disabled", rx_empty, 1);
        chk(host_irq == 1'b1, "R1 transmit FIFO untouched when disabled", host_irq, 1);

        // R1 slave strap re-enables after a new reset
        do_reset(2'b01);
        chk(host_irq == 1'b0, "R9 reset clears transmit FIFO", host_irq, 0);
        xfer1(8'hE7, "R1 port live after re-strap", bsy);
        drain();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule